// File: doc/BRIEF.md
# Key-Locked Serial Register Interface

This block is the serial control port of a data converter. A host drives a clock, an active-low frame select and a serial command line. Every frame's first 24 bits form a command: an 8-bit address and a 16-bit value. The block decodes the command when the frame select goes high. All three serial lines are resampled into the block's own clock domain, so the serial clock must run well below the system clock.

Access is protected. Writes to the register file, the bank selector and the control word take effect only after a two-word key is written in order to a key address. A lock word closes access again. Reads are deferred. The host writes a read address and a data-select flag in one frame. During the next frame the serial output lane carries that register's contents instead of the parallel conversion word.

The bank selector, read address, data-select flag and lock state are brought out as a registered configuration view.

Top module: `spi_locked_regif`

## Requirements
- R1: After a synchronous reset the map is locked, bank 0 is selected, data-select is 0, the read address is 0x00 and the serial output is 0.
- R2: The map unlocks only after a frame writing 0xB38F to address 0xFE is followed, in the next complete non-no-op frame, by 0xABCD to address 0xFE. Any other order leaves it locked.
- R3: Writing 0x1234 to address 0xFE locks the map and clears data-select.
- R4: While the map is locked, frames to any address other than 0xFE leave the register file, bank, read address and data-select unchanged, so the output lane keeps carrying conversion data.
- R5: When unlocked, writing 0x0002 to address 0x02 selects bank 1, and any other value selects bank 0. The general registers at addresses 0x00 and 0x03 to NUM_REGS-1 are stored separately per bank.
- R6: When unlocked, a write to address 0x01 loads the read address from value bits [15:8] and data-select from bit 0. If bit 1 is set, the write instead clears the bank, read address and data-select, and the lock state is kept.
- R7: A frame is sampled on rising serial-clock edges, MSB first: address[7:0], then value[15:0]. It is decoded when the frame select rises. In a 48-bit frame, bits after the 24th are ignored.
- R8: A frame that ends before 24 bits is discarded and restarts the unlock sequence.
- R9: An all-zero 24-bit command is a no-op. It changes no register and no unlock progress.
- R10: At the start of each frame the output lane loads a 16-bit word, MSB first. The first bit appears after the frame select falls, and each later bit follows a falling serial-clock edge. After the 16th bit the lane shows 0. With data-select 0, the word is the conversion input sampled at frame start.
- R11: With data-select 1, the word depends on the read address. Address 0x01 returns {read address, 7'b0, data-select}. Address 0x02 returns the bank in bit 0. Address 0xFE returns the unlock state in bit 0. General addresses below NUM_REGS return the stored word of the current bank. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial command input |
| conv_data | input | 16 | Parallel conversion word |
| spi_dout | output | 1 | Serial output lane (conversion or readback) |
| cfg_unlocked | output | 1 | Map unlocked |
| cfg_bank | output | 1 | Selected bank |
| cfg_data_sel | output | 1 | Readback selected for the next frame |
| cfg_read_addr | output | 8 | Register address to return |

## Verification
A command takes effect on the configuration view about five system clocks after the frame select rises: three resampling stages, the decode pulse and the register update. The bench waits sixteen clocks before comparing those outputs. A requested readback is due in the following frame. The bench predicts that word before the frame starts and collects each output bit just before the rising serial-clock edge, eight clocks after the preceding falling edge. The bit shift needs about five clocks, so the value is settled when sampled.

// File: rtl/spi_lrk_pkg.sv
package spi_lrk_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] KEY_ADDR  = 8'hFE;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h01;
  localparam logic [ADDR_W-1:0] BANK_ADDR = 8'h02;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 16'hB38F;
  localparam logic [DATA_W-1:0] KEY_SECOND = 16'hABCD;
  localparam logic [DATA_W-1:0] LOCK_WORD  = 16'h1234;
  localparam logic [DATA_W-1:0] BANK1_WORD = 16'h0002;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] val;
  } cmd_t;
endpackage

// File: rtl/spi_lrk_rx.sv
module spi_lrk_rx
  import spi_lrk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic cmd_valid,
  output logic cmd_abort,
  output cmd_t cmd,
  output logic frame_start,
  output logic shift_out
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [SYNC_STAGES:0] sclk_sr, cs_sr, sdi_sr;
  logic [FRAME_W-1:0]   shreg;
  logic [CNT_W-1:0]     bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sr <= '0;
      cs_sr   <= '1;
      sdi_sr  <= '0;
    end else begin
      sclk_sr <= {sclk_sr[SYNC_STAGES-1:0], sclk};
      cs_sr   <= {cs_sr[SYNC_STAGES-1:0], cs_n};
      sdi_sr  <= {sdi_sr[SYNC_STAGES-1:0], sdi};
    end
  end

  logic sclk_now, sclk_prev, cs_now, cs_prev, sdi_now;
  logic sclk_rise, sclk_fall, cs_rise, cs_fall;

  always_comb begin
    sclk_now  = sclk_sr[SYNC_STAGES-1];
    sclk_prev = sclk_sr[SYNC_STAGES];
    cs_now    = cs_sr[SYNC_STAGES-1];
    cs_prev   = cs_sr[SYNC_STAGES];
    sdi_now   = sdi_sr[SYNC_STAGES-1];
    sclk_rise = sclk_now & ~sclk_prev;
    sclk_fall = ~sclk_now & sclk_prev;
    cs_rise   = cs_now & ~cs_prev;
    cs_fall   = ~cs_now & cs_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg       <= '0;
      bit_cnt     <= '0;
      cmd_valid   <= 1'b0;
      cmd_abort   <= 1'b0;
      frame_start <= 1'b0;
      shift_out   <= 1'b0;
    end else begin
      cmd_valid   <= 1'b0;
      cmd_abort   <= 1'b0;
      frame_start <= cs_fall;
      shift_out   <= sclk_fall & ~cs_now;
      if (cs_fall) begin
        bit_cnt <= '0;
      end else if (cs_rise) begin
        bit_cnt <= '0;
        if (bit_cnt == CNT_W'(FRAME_W)) cmd_valid <= 1'b1;
        else                            cmd_abort <= 1'b1;
      end else if (!cs_now && sclk_rise && bit_cnt < CNT_W'(FRAME_W)) begin
        shreg   <= {shreg[FRAME_W-2:0], sdi_now};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign cmd = cmd_t'(shreg);
endmodule

// File: rtl/spi_lrk_core.sv
module spi_lrk_core
  import spi_lrk_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_abort,
  input  cmd_t              cmd,
  output logic              unlocked,
  output logic              bank,
  output logic              data_sel,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rb_word
);
  localparam int REG_AW = $clog2(NUM_REGS);
  localparam int DEPTH  = 2 * NUM_REGS;

  logic [DATA_W-1:0] mem [0:DEPTH-1];
  logic [DATA_W-1:0] mem_q;
  logic              key_armed;

  logic is_nop, is_key, is_ctrl, is_bank, in_range, wr_en;
  logic [REG_AW:0] wr_idx, rd_idx;

  always_comb begin
    is_nop   = (cmd == '0);
    is_key   = (cmd.addr == KEY_ADDR);
    is_ctrl  = (cmd.addr == CTRL_ADDR);
    is_bank  = (cmd.addr == BANK_ADDR);
    in_range = (cmd.addr < ADDR_W'(NUM_REGS));
    wr_en    = cmd_valid && !is_nop && unlocked && !is_key && !is_ctrl
               && !is_bank && in_range;
    wr_idx   = {bank, cmd.addr[REG_AW-1:0]};
    rd_idx   = {bank, rd_addr[REG_AW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= cmd.val;
  end

  always_ff @(posedge clk) begin
    mem_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked  <= 1'b0;
      key_armed <= 1'b0;
      bank      <= 1'b0;
      data_sel  <= 1'b0;
      rd_addr   <= '0;
    end else if (cmd_abort) begin
      key_armed <= 1'b0;
    end else if (cmd_valid && !is_nop) begin
      key_armed <= is_key && (cmd.val == KEY_FIRST);
      if (is_key) begin
        if (cmd.val == KEY_SECOND && key_armed) unlocked <= 1'b1;
        if (cmd.val == LOCK_WORD) begin
          unlocked <= 1'b0;
          data_sel <= 1'b0;
        end
      end else if (unlocked) begin
        if (is_bank) begin
          bank <= (cmd.val == BANK1_WORD);
        end else if (is_ctrl) begin
          if (cmd.val[1]) begin
            bank     <= 1'b0;
            data_sel <= 1'b0;
            rd_addr  <= '0;
          end else begin
            rd_addr  <= cmd.val[15:8];
            data_sel <= cmd.val[0];
          end
        end
      end
    end
  end

  logic [DATA_W-1:0] rb_next;
  always_comb begin
    if (rd_addr == CTRL_ADDR)
      rb_next = {rd_addr, 7'b0, data_sel};
    else if (rd_addr == BANK_ADDR)
      rb_next = {15'b0, bank};
    else if (rd_addr == KEY_ADDR)
      rb_next = {15'b0, unlocked};
    else if (rd_addr < ADDR_W'(NUM_REGS))
      rb_next = mem_q;
    else
      rb_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rb_word <= '0;
    else     rb_word <= rb_next;
  end
endmodule

// File: rtl/spi_lrk_tx.sv
module spi_lrk_tx
  import spi_lrk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              shift_out,
  input  logic [DATA_W-1:0] load_word,
  output logic              dout
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)              sh <= '0;
    else if (frame_start) sh <= load_word;
    else if (shift_out)   sh <= {sh[DATA_W-2:0], 1'b0};
  end

  assign dout = sh[DATA_W-1];
endmodule

// File: rtl/spi_locked_regif.sv
module spi_locked_regif
  import spi_lrk_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_sdi,
  input  logic [15:0] conv_data,
  output logic        spi_dout,
  output logic        cfg_unlocked,
  output logic        cfg_bank,
  output logic        cfg_data_sel,
  output logic [7:0]  cfg_read_addr
);
  logic              cmd_valid, cmd_abort, frame_start, shift_out;
  cmd_t              cmd_word;
  logic [DATA_W-1:0] rb_word, load_word;

  spi_lrk_rx #(.SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .sdi(spi_sdi),
    .cmd_valid(cmd_valid), .cmd_abort(cmd_abort), .cmd(cmd_word),
    .frame_start(frame_start), .shift_out(shift_out)
  );

  spi_lrk_core #(.NUM_REGS(NUM_REGS)) i_core (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_abort(cmd_abort),
    .cmd(cmd_word), .unlocked(cfg_unlocked), .bank(cfg_bank),
    .data_sel(cfg_data_sel), .rd_addr(cfg_read_addr), .rb_word(rb_word)
  );

  assign load_word = cfg_data_sel ? rb_word : conv_data;

  spi_lrk_tx i_tx (
    .clk(clk), .rst(rst), .frame_start(frame_start), .shift_out(shift_out),
    .load_word(load_word), .dout(spi_dout)
  );
endmodule

// File: rtl/spi_locked_regif_chk.sv
module spi_locked_regif_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic        cmd_abort,
  input logic [23:0] cmd_word,
  input logic        cfg_unlocked,
  input logic        cfg_bank,
  input logic        cfg_data_sel,
  input logic [7:0]  cfg_read_addr
);
  // R2: unlocking only follows the second key word
  a_r2_unlock_needs_key: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_unlocked) |-> ($past(cmd_valid) && $past(cmd_word) == 24'hFEABCD));

  // R3: lock word closes the map and drops readback
  a_r3_lock_word: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word == 24'hFE1234) |=> (!cfg_unlocked && !cfg_data_sel));

  // R4: locked frames to other addresses change nothing
  a_r4_locked_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cfg_unlocked && cmd_word[23:16] != 8'hFE)
    |=> ($stable({cfg_bank, cfg_data_sel, cfg_read_addr}) && !cfg_unlocked));

  // R4: readback never selected while locked
  a_r4_sel_needs_unlock: assert property (@(posedge clk) disable iff (rst)
    cfg_data_sel |-> cfg_unlocked);

  // R8: discarded frame leaves configuration alone
  a_r8_abort_stable: assert property (@(posedge clk) disable iff (rst)
    cmd_abort |=> $stable({cfg_unlocked, cfg_bank, cfg_data_sel, cfg_read_addr}));

  // R9: all-zero command is a no-op
  a_r9_nop_stable: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word == 24'h0)
    |=> $stable({cfg_unlocked, cfg_bank, cfg_data_sel, cfg_read_addr}));
endmodule

bind spi_locked_regif spi_locked_regif_chk i_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_abort(cmd_abort),
  .cmd_word(cmd_word), .cfg_unlocked(cfg_unlocked), .cfg_bank(cfg_bank),
  .cfg_data_sel(cfg_data_sel), .cfg_read_addr(cfg_read_addr)
);

// File: tb/test_spi_locked_regif.sv
module test_spi_locked_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_sdi = 1'b0;
  logic [15:0] conv_data = '0;
  logic        spi_dout, cfg_unlocked, cfg_bank, cfg_data_sel;
  logic [7:0]  cfg_read_addr;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  spi_locked_regif i_spi_locked_regif (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_sdi(spi_sdi), .conv_data(conv_data), .spi_dout(spi_dout),
    .cfg_unlocked(cfg_unlocked), .cfg_bank(cfg_bank),
    .cfg_data_sel(cfg_data_sel), .cfg_read_addr(cfg_read_addr)
  );

  // reference state
  logic        m_unl = 0, m_key = 0, m_bank = 0, m_sel = 0;
  logic [7:0]  m_rd = 0;
  logic [15:0] mm [2][16];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_rb();
    if (m_rd == 8'h01)      return {m_rd, 7'b0, m_sel};
    else if (m_rd == 8'h02) return {15'b0, m_bank};
    else if (m_rd == 8'hFE) return {15'b0, m_unl};
    else if (m_rd < 8'd16)  return mm[m_bank][m_rd[3:0]];
    else                    return 16'h0;
  endfunction

  task automatic m_update(input logic [7:0] a, input logic [15:0] v, input int nb);
    logic nk;
    if (nb < 24) begin m_key = 0; return; end
    if ({a, v} == 24'h0) return;
    nk = (a == 8'hFE) && (v == 16'hB38F);
    if (a == 8'hFE) begin
      if (v == 16'hABCD && m_key) m_unl = 1;
      if (v == 16'h1234) begin m_unl = 0; m_sel = 0; end
    end else if (m_unl) begin
      if (a == 8'h02) m_bank = (v == 16'h0002);
      else if (a == 8'h01) begin
        if (v[1]) begin m_bank = 0; m_sel = 0; m_rd = 0; end
        else begin m_rd = v[15:8]; m_sel = v[0]; end
      end else if (a < 8'd16) mm[m_bank][a[3:0]] = v;
    end
    m_key = nk;
  endtask

  task automatic do_frame(input logic [7:0] a, input logic [15:0] v, input int nb,
                          input logic [23:0] tail, input string req);
    logic [47:0] bits;
    logic [15:0] got, exp_w;
    string lane_req;
    bits = {a, v, tail};
    got  = '0;
    @(negedge clk);
    conv_data = 16'($urandom);
    exp_w    = m_sel ? m_rb() : conv_data;
    lane_req = m_sel ? "R11 readback" : "R10 conversion lane";
    repeat (2) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      spi_sdi = bits[47-i];
      repeat (8) @(negedge clk);
      if (i < 16) got[15-i] = spi_dout;
      spi_sclk = 1'b1;
      repeat (8) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    if (nb >= 17) check("R10 lane zero after 16 bits", {31'b0, spi_dout}, 32'h0);
    spi_cs_n = 1'b1;
    spi_sdi  = 1'b0;
    repeat (16) @(negedge clk);
    if (nb >= 16) check(lane_req, {16'h0, got}, {16'h0, exp_w});
    m_update(a, v, nb);
    check(req, {21'b0, cfg_unlocked, cfg_bank, cfg_data_sel, cfg_read_addr},
               {21'b0, m_unl, m_bank, m_sel, m_rd});
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] v, input string req);
    do_frame(a, v, 24, 24'h0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 reset cfg", {21'b0, cfg_unlocked, cfg_bank, cfg_data_sel, cfg_read_addr}, 32'h0);
    check("R1 reset dout", {31'b0, spi_dout}, 32'h0);

    // R2 ordering
    wr(8'hFE, 16'hABCD, "R2 second key alone");
    wr(8'hFE, 16'hB38F, "R2 first key");
    wr(8'h03, 16'h5555, "R2 intervening frame");
    wr(8'hFE, 16'hABCD, "R2 broken order stays locked");
    // R8 short frame resets progress
    wr(8'hFE, 16'hB38F, "R8 first key");
    do_frame(8'h00, 16'h0000, 20, 24'h0, "R8 short frame");
    wr(8'hFE, 16'hABCD, "R8 still locked");
    // R9 no-op between key words keeps progress
    wr(8'hFE, 16'hB38F, "R9 first key");
    wr(8'h00, 16'h0000, "R9 nop");
    wr(8'hFE, 16'hABCD, "R2 unlock in order");
    check("R2 unlocked", {31'b0, cfg_unlocked}, 32'h1);

    // fill both banks (R5)
    for (int b = 0; b < 2; b++) begin
      wr(8'h02, b ? 16'h0002 : 16'h0000, "R5 bank select");
      for (int r = 0; r < 16; r++)
        if (r != 1 && r != 2) wr(8'(r), 16'(16'hA000 + b * 16'h0100 + r * 16'h0011), "R5 fill");
    end
    // R11 readback across banks
    wr(8'h01, 16'h0501, "R6 ctrl read 0x05");
    wr(8'h01, 16'h0F01, "R11 bank1 reg5 then 0x0F");
    wr(8'h02, 16'h0000, "R5 bank0");
    wr(8'h01, 16'h0101, "R11 bank0 reg15 then ctrl view");
    wr(8'h01, 16'h4001, "R11 ctrl view then out of range");
    wr(8'h01, 16'hFE01, "R11 out of range then lock view");
    wr(8'h01, 16'h0201, "R11 lock view then bank view");
    wr(8'h01, 16'h0500, "R11 bank view then stop");

    // R7 48-bit frame: tail ignored
    do_frame(8'h07, 16'h7E57, 48, 24'h08FFFF, "R7 long frame");
    wr(8'h01, 16'h0701, "R7 request reg7");
    wr(8'h01, 16'h0801, "R7 reg7 value then reg8");
    // R6 soft reset bit
    wr(8'h02, 16'h0002, "R5 bank1");
    wr(8'h01, 16'h3303, "R6 soft reset");
    // R3 lock clears data-select
    wr(8'h01, 16'h0501, "R6 select readback");
    wr(8'hFE, 16'h1234, "R3 lock");
    // R4 locked writes ignored
    wr(8'h05, 16'hDEAD, "R4 locked data write");
    wr(8'h02, 16'h0002, "R4 locked bank write");
    wr(8'h01, 16'h0501, "R4 locked ctrl write");
    wr(8'hFE, 16'hB38F, "R2 key");
    wr(8'hFE, 16'hABCD, "R2 key");
    wr(8'h01, 16'h0501, "R4 read reg5");
    wr(8'h01, 16'h0000, "R4 reg5 unchanged");

    // random mix
    for (int n = 0; n < 60; n++) begin
      int k;
      logic [7:0] ra;
      k = int'($urandom % 10);
      case (k)
        0: begin wr(8'hFE, 16'hB38F, "R2 rand key"); wr(8'hFE, 16'hABCD, "R2 rand key"); end
        1: wr(8'hFE, 16'h1234, "R3 rand lock");
        2: wr(8'h02, ($urandom % 2) ? 16'h0002 : 16'($urandom), "R5 rand bank");
        3: begin
          case ($urandom % 5)
            0: ra = 8'h01; 1: ra = 8'h02; 2: ra = 8'hFE; 3: ra = 8'h40;
            default: ra = 8'($urandom % 16);
          endcase
          wr(8'h01, {ra, 6'b0, ($urandom % 8) == 0, 1'($urandom)}, "R6 rand ctrl");
        end
        4, 5: wr(8'($urandom % 16), 16'($urandom), "R5 rand write");
        6: wr(8'h00, 16'h0000, "R9 rand nop");
        7: do_frame(8'($urandom), 16'($urandom), 16 + int'($urandom % 8), 24'h0, "R8 rand short");
        8: do_frame(8'($urandom % 16), 16'($urandom), 48, 24'($urandom), "R7 rand long");
        default: wr(8'hFE, 16'($urandom), "R2 rand key addr");
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule